// File: doc/BRIEF.md
# Flash Operation Interrupt Status Register

This block keeps three sticky completion flags for a flash memory controller: one for reads, one for programming and one for erases. When a command is written, its code is decoded and kept. When the operation-complete strobe arrives, the flag that belongs to the kept command sets. The host reads the flags through a 16-bit status word. The block also raises a single combined interrupt line while any flag is pending.

A flag can be cleared in three ways. The host can write a 0 to its bit. A cold or warm reset clears it. When auto-clear mode is on, any new command write clears all flags. A completion always beats a clear that arrives in the same cycle, so no finished operation goes unreported. The two reset types give different start values: a cold reset leaves the read flag pending, and a warm reset leaves every flag off.

Top module: `flash_irq_status`

## Requirements
- R1: In `status_o`, bit 7 is the read flag, bit 6 the program flag and bit 5 the erase flag. Every other bit reads 0.
- R2: One cycle after `cold_rst` is sampled high, `status_o[7:5]` is 3'b100.
- R3: One cycle after `warm_rst` is sampled high while `cold_rst` is low, `status_o[7:5]` is 3'b000. Cold reset takes priority when both are high.
- R4: If the most recently written command code is 16'h0000, 16'h0003 or 16'h0005, an `op_done` pulse sets bit 7 at the next edge.
- R5: If the most recently written command code is 16'h0080 or 16'h007F, an `op_done` pulse sets bit 6 at the next edge.
- R6: If the most recently written command code is 16'h0094 or 16'h0030, an `op_done` pulse sets bit 5 at the next edge.
- R7: If the most recently written command code is any other value, an `op_done` pulse changes no flag.
- R8: A host write with `host_wdata` bit k at 0 clears the flag in bit k (k = 5, 6, 7). A 1 in a bit leaves that flag unchanged.
- R9: When `auto_clr` is high, a command write clears all three flags at the next edge. When `auto_clr` is low, a command write leaves the flags unchanged.
- R10: If a set and a clear reach the same flag in the same cycle, the flag ends at 1. `op_done` in the same cycle as a command write uses the code written earlier.
- R11: `irq_o` is registered and, at every cycle, equals the OR of `status_o[7:5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high cold reset |
| warm_rst | input | 1 | Synchronous active-high warm/hot reset |
| host_we | input | 1 | Host write strobe to the status word |
| host_wdata | input | 16 | Host write data; a 0 in a flag bit clears that flag |
| cmd_we | input | 1 | Command register write strobe |
| cmd_code | input | 16 | Command code written with `cmd_we` |
| op_done | input | 1 | Pulse: the current operation has finished |
| auto_clr | input | 1 | Auto-clear mode enable |
| status_o | output | 16 | Status word holding the three flags |
| irq_o | output | 1 | Combined interrupt, high while any flag is set |

## Verification
A wrong decoded command class stays hidden until the next `op_done`. At that point the wrong bit of `status_o` sets, or no bit sets, one cycle after the strobe. A flag that is stuck or has the wrong reset value shows up one cycle after a reset, and `irq_o` disagrees with the OR of the flag bits in the same cycle that the flag is wrong. Same-cycle collisions, where a set meets a host clear or a set meets an auto-clear command write, are driven on purpose so that a lost completion appears as a 0 on the next read.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int unsigned CMD_W  = 16;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned NFLAG  = 3;

  // Bit positions of the flags in the status word (index 0 = read, 1 = program, 2 = erase)
  localparam int unsigned POS_RD = 7;
  localparam int unsigned POS_PG = 6;
  localparam int unsigned POS_ER = 5;

  typedef enum logic [1:0] {
    OPC_NONE  = 2'd0,
    OPC_READ  = 2'd1,
    OPC_PROG  = 2'd2,
    OPC_ERASE = 2'd3
  } op_class_t;

  localparam logic [CMD_W-1:0] CODE_RD_A = 16'h0000;
  localparam logic [CMD_W-1:0] CODE_RD_B = 16'h0003;
  localparam logic [CMD_W-1:0] CODE_RD_C = 16'h0005;
  localparam logic [CMD_W-1:0] CODE_PG_A = 16'h0080;
  localparam logic [CMD_W-1:0] CODE_PG_B = 16'h007F;
  localparam logic [CMD_W-1:0] CODE_ER_A = 16'h0094;
  localparam logic [CMD_W-1:0] CODE_ER_B = 16'h0030;
endpackage

// File: rtl/op_cmd_decoder.sv
module op_cmd_decoder
  import flash_irq_pkg::*;
(
  input  logic [CMD_W-1:0] code_i,
  output op_class_t        cls_o
);
  always_comb begin
    unique case (code_i)
      CODE_RD_A, CODE_RD_B, CODE_RD_C: cls_o = OPC_READ;
      CODE_PG_A, CODE_PG_B:            cls_o = OPC_PROG;
      CODE_ER_A, CODE_ER_B:            cls_o = OPC_ERASE;
      default:                         cls_o = OPC_NONE;
    endcase
  end
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
  parameter bit COLD_VAL = 1'b0
) (
  input  logic clk,
  input  logic cold_rst,
  input  logic warm_rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic flag_o
);
  // Reset first, then set, then clear: a completion is never lost to a clear
  always_comb begin
    if (cold_rst)      nxt_o = COLD_VAL;
    else if (warm_rst) nxt_o = 1'b0;
    else if (set_i)    nxt_o = 1'b1;
    else if (clr_i)    nxt_o = 1'b0;
    else               nxt_o = flag_o;
  end

  always_ff @(posedge clk) flag_o <= nxt_o;
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import flash_irq_pkg::*;
(
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              warm_rst,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              op_done,
  input  logic              auto_clr,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  localparam int unsigned POS [NFLAG] = '{POS_RD, POS_PG, POS_ER};
  localparam op_class_t   CLS [NFLAG] = '{OPC_READ, OPC_PROG, OPC_ERASE};
  localparam bit          CV  [NFLAG] = '{1'b1, 1'b0, 1'b0};

  op_class_t        dec_cls;
  op_class_t        cls_q;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_d;
  logic             auto_hit;

  op_cmd_decoder u_dec (
    .code_i (cmd_code),
    .cls_o  (dec_cls)
  );

  // The class of the command now running; op_done refers to this stored value
  always_ff @(posedge clk) begin
    if (cold_rst || warm_rst) cls_q <= OPC_NONE;
    else if (cmd_we)          cls_q <= dec_cls;
  end

  assign auto_hit = cmd_we && auto_clr;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic set_w, clr_w;
    assign set_w = op_done && (cls_q == CLS[i]);
    assign clr_w = (host_we && !host_wdata[POS[i]]) || auto_hit;
    irq_flag_cell #(.COLD_VAL(CV[i])) u_cell (
      .clk      (clk),
      .cold_rst (cold_rst),
      .warm_rst (warm_rst),
      .set_i    (set_w),
      .clr_i    (clr_w),
      .nxt_o    (flag_d[i]),
      .flag_o   (flag_q[i])
    );
  end

  always_comb begin
    status_o = '0;
    for (int i = 0; i < NFLAG; i++) status_o[POS[i]] = flag_q[i];
  end

  always_ff @(posedge clk) irq_o <= |flag_d;
endmodule

// File: rtl/flash_irq_status_chk.sv
module flash_irq_status_chk
  import flash_irq_pkg::*;
(
  input logic              clk,
  input logic              cold_rst,
  input logic              warm_rst,
  input logic              host_we,
  input logic [DATA_W-1:0] host_wdata,
  input logic              cmd_we,
  input logic              op_done,
  input logic              auto_clr,
  input op_class_t         cls_q,
  input logic [DATA_W-1:0] status_o,
  input logic              irq_o
);
  logic rst;
  assign rst = cold_rst || warm_rst;

  // R1
  unused_bits_zero_chk: assert property (@(posedge clk)
    (status_o & ~16'h00E0) == 16'h0000);

  // R2
  cold_default_chk: assert property (@(posedge clk)
    cold_rst |=> status_o[7:5] == 3'b100);

  // R3
  warm_default_chk: assert property (@(posedge clk)
    (warm_rst && !cold_rst) |=> status_o[7:5] == 3'b000);

  // R10
  read_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (op_done && cls_q == OPC_READ) |=> status_o[POS_RD]);

  // R10
  prog_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (op_done && cls_q == OPC_PROG) |=> status_o[POS_PG]);

  // R10
  erase_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (op_done && cls_q == OPC_ERASE) |=> status_o[POS_ER]);

  // R8
  write_ones_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_wdata[7:5] == 3'b111 && !cmd_we && !op_done)
      |=> $stable(status_o));

  // R9
  auto_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && auto_clr && !op_done) |=> status_o[7:5] == 3'b000);

  // R11
  irq_matches_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == |status_o[7:5]);
endmodule

bind flash_irq_status flash_irq_status_chk u_chk (
  .clk        (clk),
  .cold_rst   (cold_rst),
  .warm_rst   (warm_rst),
  .host_we    (host_we),
  .host_wdata (host_wdata),
  .cmd_we     (cmd_we),
  .op_done    (op_done),
  .auto_clr   (auto_clr),
  .cls_q      (cls_q),
  .status_o   (status_o),
  .irq_o      (irq_o)
);

// File: tb/flash_irq_status_test.sv
module flash_irq_status_test;
  logic        clk = 1'b0;
  logic        cold_rst, warm_rst, host_we, cmd_we, op_done, auto_clr;
  logic [15:0] host_wdata, cmd_code, status_o;
  logic        irq_o;
  int          checks = 0;
  int          failures = 0;
  bit          done_flag = 1'b0;

  always #5 clk = ~clk;

  flash_irq_status uut (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .host_we(host_we), .host_wdata(host_wdata),
    .cmd_we(cmd_we), .cmd_code(cmd_code), .op_done(op_done),
    .auto_clr(auto_clr), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [15:0] exp_st);
    checks++;
    if (status_o !== exp_st || irq_o !== (exp_st[7:5] != 3'b000)) begin
      failures++;
      $display("FAIL %s status=%h irq=%b expected status=%h irq=%b",
               req, status_o, irq_o, exp_st, exp_st[7:5] != 3'b000);
    end
  endtask

  task automatic idle();
    cold_rst = 0; warm_rst = 0; host_we = 0; cmd_we = 0; op_done = 0;
    host_wdata = '0; cmd_code = '0;
  endtask

  // Hold the driven inputs for one edge, then return them to idle and sample
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_cmd(logic [15:0] code);
    cmd_we = 1; cmd_code = code; step();
  endtask

  task automatic do_done();
    op_done = 1; step();
  endtask

  task automatic do_host(logic [15:0] d);
    host_we = 1; host_wdata = d; step();
  endtask

  task automatic t_cold();
    cold_rst = 1; step();
    check("R2 cold reset", 16'h0080);
    cold_rst = 1; warm_rst = 1; step();
    check("R3 cold over warm", 16'h0080);
  endtask

  task automatic t_host_basic();
    do_host(16'hFFFF); check("R8 write ones keeps", 16'h0080);
    do_host(16'h0000); check("R8 write zero clears", 16'h0000);
    do_host(16'hFFFF); check("R8 write ones no set", 16'h0000);
  endtask

  task automatic t_codes();
    logic [15:0] rd [3] = '{16'h0000, 16'h0003, 16'h0005};
    logic [15:0] pg [2] = '{16'h0080, 16'h007F};
    logic [15:0] er [2] = '{16'h0094, 16'h0030};
    auto_clr = 0;
    foreach (rd[i]) begin
      do_cmd(rd[i]); check("R4 cmd no set yet", 16'h0000);
      do_done(); check("R4 read flag R1 bit7", 16'h0080);
      do_host(16'h0000);
    end
    foreach (pg[i]) begin
      do_cmd(pg[i]); do_done(); check("R5 program flag R1 bit6", 16'h0040);
      do_host(16'h0000);
    end
    foreach (er[i]) begin
      do_cmd(er[i]); do_done(); check("R6 erase flag R1 bit5", 16'h0020);
      do_host(16'h0000);
    end
  endtask

  task automatic t_partial_and_auto();
    auto_clr = 0;
    do_cmd(16'h0005); do_done(); do_cmd(16'h0080); do_done();
    do_cmd(16'h0030); do_done();
    check("R1 all three", 16'h00E0);
    do_host(16'h00BF); check("R8 clear only bit6", 16'h00A0);
    do_cmd(16'h0003); check("R9 auto off keeps", 16'h00A0);
    auto_clr = 1;
    do_cmd(16'h0001); check("R9 auto on clears", 16'h0000);
    do_done(); check("R7 unknown code no set", 16'h0000);
    auto_clr = 0;
  endtask

  task automatic t_collide();
    auto_clr = 0;
    do_cmd(16'h0080);
    op_done = 1; host_we = 1; host_wdata = 16'h0000; step();
    check("R10 set beats host clear", 16'h0040);
    auto_clr = 1;
    op_done = 1; cmd_we = 1; cmd_code = 16'h0094; step();
    check("R10 set beats auto clear, old code", 16'h0040);
    auto_clr = 0;
    do_done(); check("R10 new code latched", 16'h0060);
  endtask

  task automatic t_warm();
    warm_rst = 1; step();
    check("R3 warm reset", 16'h0000);
    do_done(); check("R3 warm clears command", 16'h0000);
    do_cmd(16'h0003); do_done(); check("R11 irq after set", 16'h0080);
    cold_rst = 1; step();
    check("R2 cold again", 16'h0080);
  endtask

  initial begin
    idle(); auto_clr = 0;
    @(negedge clk);
    t_cold();
    t_host_basic();
    t_codes();
    t_partial_and_auto();
    t_collide();
    t_warm();
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule